// File: doc/BRIEF.md
# Reset-Time Operating Mode Latch

This block fixes the chip's operating mode from two strap pins. While the chip is held in reset, the two pins pass through a short clocked pipeline. The four mode control bits follow the pipeline's output, so mode-dependent reset values are already correct during reset. When the reset pin is released, a small synchronizer delays the internal release. On the first clock edge at which the internal release is seen, the control bits load once and then stay fixed until reset is asserted again.

The pin pipeline is one stage deeper than the reset synchronizer. Because of that, the value captured is the one the pins held at the last clock edge before reset rose. The pins may therefore change at the same moment reset rises. The block also gives a two-bit mode code and the value that an upper-address output port must drive while in reset.

Top module: `mode_strap_latch`

## Requirements
- R1: Pins mode_b=1, mode_a=0 give normal single-chip mode: boot_en=0, special_en=0, expand_en=0, vec_reloc=0.
- R2: Pins mode_b=1, mode_a=1 give normal expanded mode: boot_en=0, special_en=0, expand_en=1, vec_reloc=0.
- R3: Pins mode_b=0, mode_a=0 give special bootstrap mode: boot_en=1, special_en=1, expand_en=0, vec_reloc=1.
- R4: Pins mode_b=0, mode_a=1 give special test mode: boot_en=0, special_en=1, expand_en=1, vec_reloc=1.
- R5: mode_code is {special_en, expand_en}: 0 is single-chip, 1 is expanded, 2 is bootstrap, 3 is test.
- R6: hiaddr_rst is all ones in the expanded and test modes, and all zeros in the single-chip and bootstrap modes.
- R7: While rst_n is low, a pin change applied between clock edges shows on the control outputs after exactly SYNC_DEPTH+1 rising edges. Before that, the outputs keep the previous mode.
- R8: After rst_n rises, the latched mode is the one the pins held at the last rising edge before the rise. A pin change made together with the rise has no effect. The latched value shows after exactly SYNC_DEPTH rising edges.
- R9: Once latched, the control outputs hold, whatever the mode pins do, until rst_n goes low again.
- R10: When reset is asserted again, the outputs return to following the pins with the R7 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset pin, active low, asserts asynchronously |
| mode_a | input | 1 | Mode strap pin A |
| mode_b | input | 1 | Mode strap pin B |
| boot_en | output | 1 | Boot ROM enable |
| special_en | output | 1 | Special mode |
| expand_en | output | 1 | Expanded bus mode |
| vec_reloc | output | 1 | Interrupt vector relocation |
| mode_code | output | 2 | {special_en, expand_en} |
| hiaddr_rst | output | PORT_W | Reset value of the upper-address port |

## Verification
The bench builds the block with the defaults: SYNC_DEPTH=2 and PORT_W=8. With these values the reset synchronizer is a single stage. This makes the alignment between the pin pipeline and the release visible at a one-edge granularity. Changing the pins together with the rise of reset therefore shows directly whether the capture comes from before or after the rise. The 8-bit port width covers the 0xFF and 0x00 reset values.

// File: rtl/mode_strap_latch.sv
module mode_strap_latch #(
  parameter int SYNC_DEPTH = 2,
  parameter int PORT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_a,
  input  logic              mode_b,
  output logic              boot_en,
  output logic              special_en,
  output logic              expand_en,
  output logic              vec_reloc,
  output logic [1:0]        mode_code,
  output logic [PORT_W-1:0] hiaddr_rst
);
  localparam int RST_DEPTH = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] pipe_a, pipe_b;
  logic [RST_DEPTH-1:0]  rst_q;
  logic                  locked;
  logic                  pa, pb;

  always_ff @(posedge clk) begin
    pipe_a <= {pipe_a[SYNC_DEPTH-2:0], mode_a};
    pipe_b <= {pipe_b[SYNC_DEPTH-2:0], mode_b};
  end

  assign pa = pipe_a[SYNC_DEPTH-1];
  assign pb = pipe_b[SYNC_DEPTH-1];

  generate
    if (RST_DEPTH == 1) begin : g_rst1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rst_q <= '0;
        else        rst_q <= 1'b1;
    end else begin : g_rstn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rst_q <= '0;
        else        rst_q <= {rst_q[RST_DEPTH-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                locked <= 1'b0;
    else if (rst_q[RST_DEPTH-1]) locked <= 1'b1;

  always_ff @(posedge clk)
    if (!locked) begin
      boot_en    <= ~pb & ~pa;
      special_en <= ~pb;
      expand_en  <= pa;
      vec_reloc  <= ~pb;
    end

  assign mode_code  = {special_en, expand_en};
  assign hiaddr_rst = {PORT_W{expand_en}};

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable({boot_en, special_en, expand_en, vec_reloc}))
    else $error("latched mode changed after release");

  p_boot_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
    boot_en |-> (special_en && vec_reloc && !expand_en))
    else $error("boot enable outside bootstrap pattern");

  p_reloc_special_r4: assert property (@(posedge clk) disable iff (!rst_n)
    special_en == vec_reloc)
    else $error("vector relocation disagrees with special mode");

  p_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hiaddr_rst == '0 || hiaddr_rst == '1) && (hiaddr_rst[0] == mode_code[0]))
    else $error("port reset value not uniform or mismatched");
endmodule

// File: tb/test_mode_strap_latch.sv
module test_mode_strap_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_a = 1'b0, mode_b = 1'b1;
  logic boot_en, special_en, expand_en, vec_reloc;
  logic [1:0] mode_code;
  logic [7:0] hiaddr_rst;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mode_strap_latch #(.SYNC_DEPTH(2), .PORT_W(8)) i_mode_strap_latch (
    .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
    .boot_en(boot_en), .special_en(special_en), .expand_en(expand_en),
    .vec_reloc(vec_reloc), .mode_code(mode_code), .hiaddr_rst(hiaddr_rst));

  function automatic logic [13:0] expect_of(input logic b, input logic a);
    logic bo, sp, ex, rl;
    bo = !b && !a; sp = !b; ex = a; rl = !b;
    return {bo, sp, ex, rl, sp, ex, {8{ex}}};
  endfunction

  function automatic string req_of(input logic b, input logic a);
    case ({b, a})
      2'b10: return "R1";
      2'b11: return "R2";
      2'b00: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic b, input logic a);
    logic [13:0] exp, act;
    exp = expect_of(b, a);
    act = {boot_en, special_en, expand_en, vec_reloc, mode_code, hiaddr_rst};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h (bits/R5 code/R6 port)", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_track(input logic b, input logic a);
    mode_b = b; mode_a = a;
    edges(3);
    chk(req_of(b, a), b, a);
  endtask

  task automatic t_latency_r7(input logic ob, input logic oa, input logic nb, input logic na);
    mode_b = ob; mode_a = oa;
    edges(4);
    mode_b = nb; mode_a = na;
    edges(2);
    chk("R7 early", ob, oa);
    edges(1);
    chk("R7 late", nb, na);
  endtask

  task automatic t_release_r8(input logic ob, input logic oa, input logic nb, input logic na);
    rst_n = 1'b0; mode_b = ob; mode_a = oa;
    edges(4);
    rst_n = 1'b1; mode_b = nb; mode_a = na;
    edges(2);
    chk("R8 capture", ob, oa);
    for (int i = 0; i < 8; i++) begin
      mode_b = i[0]; mode_a = i[1];
      edges(1);
    end
    chk("R9 hold", ob, oa);
    rst_n = 1'b0; mode_b = nb; mode_a = na;
    edges(3);
    chk("R10 re-track", nb, na);
  endtask

  initial begin
    edges(1);
    t_reset_track(1'b1, 1'b0);
    t_reset_track(1'b1, 1'b1);
    t_reset_track(1'b0, 1'b0);
    t_reset_track(1'b0, 1'b1);
    t_latency_r7(1'b1, 1'b0, 1'b0, 1'b1);
    t_latency_r7(1'b0, 1'b0, 1'b1, 1'b1);
    t_release_r8(1'b1, 1'b1, 1'b0, 1'b0);
    t_release_r8(1'b0, 1'b0, 1'b1, 1'b1);
    t_release_r8(1'b1, 1'b0, 1'b0, 1'b1);
    t_release_r8(1'b0, 1'b1, 1'b1, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: act=running exp=finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule